// File: doc/BRIEF.md
# Truncated Timestamp Reconstruction Unit

This unit turns a partial capture timestamp into a complete seconds and nanoseconds value. A capture point in the datapath records only the two least significant bits of the seconds count and the full 30-bit nanoseconds count. The full seconds value is rebuilt later by combining that fragment with a complete reading of the local time counter taken when the fragment is processed. Because that reading is always later than the capture, its low seconds bits can only be smaller than the captured bits if the counter has since crossed a four-second boundary. In that case the reading is first moved back by four seconds.

A request supplies the current seconds together with the captured fields. The fields arrive either as a packed 32-bit word, the form receive-side capture inserts into a frame, or as separate seconds and nanoseconds inputs. One request is accepted per cycle and its result appears with `outValid` one cycle later. The unit also returns the raw field as it should be written back into the frame: zero after a packed word has been consumed, and untouched when the separate inputs were used.

Top module: `ts_rebuild_top`

## Requirements
- R1: While `rstN` is low and after its release, before the first request, `outValid` is 0 and `outSec`, `outNsec` and `outRaw` are all 0.
- R2: `outValid` is high in the cycle after the one in which `inValid` was high, and low in the cycle after one with `inValid` low; requests may be presented in back-to-back cycles.
- R3: When `inPacked` is 1, the captured seconds fragment is taken from bits 31:30 of `inRawWord` and the captured nanoseconds from bits 29:0.
- R4: When `inPacked` is 0, the captured fields come from `inSecLow` and `inNsec`, and the value of `inRawWord` has no effect on `outSec` or `outNsec`.
- R5: `outNsec` equals the captured 30-bit nanoseconds without modification.
- R6: When the two low bits of `curSec` are greater than or equal to the captured fragment, `outSec` equals `curSec` with bits 1:0 replaced by the fragment.
- R7: When the two low bits of `curSec` are below the captured fragment, `outSec` equals (`curSec` − 4) with bits 1:0 replaced by the fragment.
- R8: When that correction applies and `curSec` is below 4, the corrected seconds saturate at 0, so `outSec` equals the fragment alone.
- R9: `outRaw` is 0 after a packed request and equals the request's `inRawWord` after a request with `inPacked` 0.
- R10: `curSec` is sampled only in the request cycle; a change to it afterwards does not alter the result already produced.
- R11: In a cycle with no request, `outSec`, `outNsec` and `outRaw` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| inPacked | input | 1 | 1: use the packed raw word, 0: use the separate fields |
| inRawWord | input | 32 | Packed capture word: seconds fragment in 31:30, nanoseconds in 29:0 |
| inSecLow | input | 2 | Captured seconds fragment (separate form) |
| inNsec | input | 30 | Captured nanoseconds (separate form) |
| curSec | input | 48 | Current seconds of the local time counter |
| outValid | output | 1 | Result strobe, one cycle after the request |
| outSec | output | 48 | Reconstructed seconds |
| outNsec | output | 30 | Reconstructed nanoseconds |
| outRaw | output | 32 | Raw field to write back into the frame |

## Verification
On every cycle the assertions check the one-cycle valid latency, that the low seconds bits of the result match the captured fragment, that a result is never ahead of the sampled current seconds nor more than three seconds behind it when no saturation is possible, the clearing of the raw field after a packed request, and that outputs hold between requests. The choice between the plain and the corrected seconds value, the saturation below four seconds, the exact unpacking of the packed word and the independence of the result from later changes of the current time are shown only by the bench's scenarios, which compare every cycle against a behavioural model.

// File: rtl/ts_rebuild_pkg.sv
package ts_rebuild_pkg;

  // Strobes handed from the control to the datapath
  typedef struct packed {
    logic load;       // capture a new result this cycle
    logic usePacked;  // take captured fields from the packed word
  } tsStrobe_t;

endpackage

// File: rtl/ts_rebuild_ctrl.sv
module ts_rebuild_ctrl
  import ts_rebuild_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inPacked,
  output tsStrobe_t strobe,
  output logic      outValid
);

  always_comb begin
    strobe.load      = inValid;
    strobe.usePacked = inPacked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2: one-cycle latency, one result per request
  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/ts_rebuild_dp.sv
module ts_rebuild_dp
  import ts_rebuild_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NSEC_W = 30,
  parameter int LOW_W  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tsStrobe_t               strobe,
  input  logic [LOW_W+NSEC_W-1:0] inRawWord,
  input  logic [LOW_W-1:0]        inSecLow,
  input  logic [NSEC_W-1:0]       inNsec,
  input  logic [SEC_W-1:0]        curSec,
  output logic [SEC_W-1:0]        outSec,
  output logic [NSEC_W-1:0]       outNsec,
  output logic [LOW_W+NSEC_W-1:0] outRaw
);

  localparam int RAW_W = LOW_W + NSEC_W;
  localparam logic [SEC_W-1:0] WRAP_SEC = SEC_W'(1) << LOW_W;

  logic [LOW_W-1:0]  capLow;
  logic [NSEC_W-1:0] capNsec;
  logic [LOW_W-1:0]  curLow;
  logic              wrapHit;
  logic              roomToStep;
  logic [SEC_W-1:0]  baseSec;
  logic [SEC_W-1:0]  nextSec;
  logic [RAW_W-1:0]  nextRaw;

  // Field selection: packed word or separate inputs
  always_comb begin
    if (strobe.usePacked) begin
      capLow  = inRawWord[RAW_W-1:NSEC_W];
      capNsec = inRawWord[NSEC_W-1:0];
      nextRaw = '0;
    end else begin
      capLow  = inSecLow;
      capNsec = inNsec;
      nextRaw = inRawWord;
    end
  end

  // Wrap correction against the current seconds snapshot
  always_comb begin
    curLow     = curSec[LOW_W-1:0];
    wrapHit    = curLow < capLow;
    roomToStep = curSec >= WRAP_SEC;
    if (!wrapHit)        baseSec = curSec;
    else if (roomToStep) baseSec = curSec - WRAP_SEC;
    else                 baseSec = '0;
    nextSec = {baseSec[SEC_W-1:LOW_W], capLow};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSec  <= '0;
      outNsec <= '0;
      outRaw  <= '0;
    end else if (strobe.load) begin
      outSec  <= nextSec;
      outNsec <= capNsec;
      outRaw  <= nextRaw;
    end
  end

  // R6/R7: result always ends in the captured fragment
  a_r6_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outSec[LOW_W-1:0] == $past(capLow));

  // R7: without saturation, result lies within one wrap period behind
  a_r7_window: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && curSec >= WRAP_SEC) |=>
      (outSec <= $past(curSec)) && (($past(curSec) - outSec) < WRAP_SEC));

  // R3: packed nanoseconds come straight from the low word bits
  a_r3_packed_nsec: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.usePacked) |=> outNsec == $past(inRawWord[NSEC_W-1:0]));

  // R5: separate-field nanoseconds pass through
  a_r5_nsec_pass: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.usePacked) |=> outNsec == $past(inNsec));

  // R9: raw field cleared after a packed request
  a_r9_raw_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.usePacked) |=> outRaw == '0);

  // R11: outputs hold between requests
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(outSec) && $stable(outNsec) && $stable(outRaw));

endmodule

// File: rtl/ts_rebuild_top.sv
module ts_rebuild_top
  import ts_rebuild_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NSEC_W = 30,
  parameter int LOW_W  = 2,
  localparam int RAW_W = LOW_W + NSEC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inPacked,
  input  logic [RAW_W-1:0]  inRawWord,
  input  logic [LOW_W-1:0]  inSecLow,
  input  logic [NSEC_W-1:0] inNsec,
  input  logic [SEC_W-1:0]  curSec,
  output logic              outValid,
  output logic [SEC_W-1:0]  outSec,
  output logic [NSEC_W-1:0] outNsec,
  output logic [RAW_W-1:0]  outRaw
);

  tsStrobe_t strobe;

  ts_rebuild_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inPacked (inPacked),
    .strobe   (strobe),
    .outValid (outValid)
  );

  ts_rebuild_dp #(
    .SEC_W  (SEC_W),
    .NSEC_W (NSEC_W),
    .LOW_W  (LOW_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inRawWord (inRawWord),
    .inSecLow  (inSecLow),
    .inNsec    (inNsec),
    .curSec    (curSec),
    .outSec    (outSec),
    .outNsec   (outNsec),
    .outRaw    (outRaw)
  );

endmodule

// File: tb/ts_rebuild_top_test.sv
`timescale 1ns/1ps
module ts_rebuild_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inPacked = 1'b0;
  logic [31:0] inRawWord = '0;
  logic [1:0]  inSecLow = '0;
  logic [29:0] inNsec = '0;
  logic [47:0] curSec = '0;
  logic        outValid;
  logic [47:0] outSec;
  logic [29:0] outNsec;
  logic [31:0] outRaw;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // reference model state
  bit      expValid = 0;
  longint  expSec = 0;
  longint  expNsec = 0;
  longint  expRaw = 0;

  always #2.5 clk = ~clk;

  ts_rebuild_top uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPacked(inPacked),
    .inRawWord(inRawWord), .inSecLow(inSecLow), .inNsec(inNsec),
    .curSec(curSec), .outValid(outValid), .outSec(outSec),
    .outNsec(outNsec), .outRaw(outRaw)
  );

  function automatic longint rebuild(longint cur, longint frag);
    longint c = cur;
    if ((cur % 4) < frag) begin
      if (cur < 4) c = 0;
      else         c = cur - 4;
    end
    return (c / 4) * 4 + frag;
  endfunction

  task automatic check(string req, longint act, longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compareAll(string req);
    check({req, " valid"}, longint'(outValid), longint'(expValid));
    check({req, " sec"},   longint'(outSec),   expSec);
    check({req, " nsec"},  longint'(outNsec),  expNsec);
    check({req, " raw"},   longint'(outRaw),   expRaw);
  endtask

  // drive at a negedge, update the model, compare at the next negedge
  task automatic doReq(bit v, bit pk, logic [31:0] raw, logic [1:0] sl,
                       logic [29:0] ns, longint cur, string req);
    longint frag, nsv;
    inValid = v; inPacked = pk; inRawWord = raw; inSecLow = sl;
    inNsec = ns; curSec = cur[47:0];
    expValid = v;
    if (v) begin
      frag = pk ? longint'(raw[31:30]) : longint'(sl);
      nsv  = pk ? longint'(raw[29:0])  : longint'(ns);
      expSec  = rebuild(cur, frag);
      expNsec = nsv;
      expRaw  = pk ? 0 : longint'(raw);
    end
    @(negedge clk);
    compareAll(req);
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 after reset");

    // R3/R6: packed, no wrap (cur low 3, frag 1)
    doReq(1, 1, {2'd1, 30'd123456}, 2'd0, 30'd0, 64'h1003, "R3 R6 packed");
    // R6 equal low bits
    doReq(1, 1, {2'd2, 30'd999999999}, 2'd0, 30'd0, 64'h2006, "R6 equal");
    // R7 wrap: cur low 1, frag 3
    doReq(1, 1, {2'd3, 30'd5}, 2'd0, 30'd0, 64'h2001, "R7 packed wrap");
    // R4/R7/R9: separate fields, raw word garbage
    doReq(1, 0, 32'hFFFF_FFFF, 2'd2, 30'd777, 64'h500, "R4 R7 R9 sep");
    doReq(1, 0, 32'h0000_0000, 2'd2, 30'd777, 64'h500, "R4 raw ignored");
    // R8 saturation
    doReq(1, 1, {2'd3, 30'd42}, 2'd0, 30'd0, 2, "R8 sat cur2");
    doReq(1, 0, 32'h1234_5678, 2'd1, 30'd1, 0, "R8 sat cur0");
    doReq(1, 1, {2'd0, 30'd9}, 2'd0, 30'd0, 3, "R6 small cur");
    doReq(1, 1, {2'd1, 30'h3FFF_FFFF}, 2'd0, 30'd0, 4, "R7 R5 cur4");
    // R10: change curSec after request, no new request
    doReq(1, 1, {2'd2, 30'd100}, 2'd0, 30'd0, 64'h7FF1, "R10 request");
    doReq(0, 1, {2'd0, 30'd1}, 2'd3, 30'd3, 64'hFFFF_FFFF, "R10 R11 cur change");
    doReq(0, 0, 32'hA5A5_A5A5, 2'd1, 30'd2, 64'h10, "R11 idle hold");
    doReq(0, 0, 32'h5A5A_5A5A, 2'd2, 30'd4, 64'h20, "R2 idle");
    // R2 back-to-back with varied patterns
    for (int i = 0; i < 60; i++) begin
      longint c;
      logic [31:0] r;
      c = {$urandom, $urandom} & 64'h0000_FFFF_FFFF_FFFF;
      if (i % 7 == 0) c = i % 4;
      r = $urandom;
      doReq((i % 5) != 4, i[0], r, r[3:2], r[29:0] ^ 30'h155, c, "R2 R6 R7 sweep");
    end
    doReq(0, 0, '0, '0, '0, 0, "R2 drain");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule